// File: doc/BRIEF.md
# ECC Error Log Registers

This block records memory ECC error events for software. A memory controller presents a correctable-error strobe and an uncorrectable-error strobe together with the failing block address, the 8-bit ECC syndrome and the channel the access used. The block keeps one logged error (address, syndrome, channel) plus two sticky flags, and shows them through a plain register port. Software reads the registers and clears the flags by writing ones to them.

The log follows a severity rule. An uncorrectable error replaces a pending correctable-error record. A correctable error never replaces anything that is already logged. A command word holds two enable bits that decide whether each flag drives a level system-error output.

Error events are a stream without back-pressure. A strobe is valid for exactly the cycle it is high. The block accepts an event on every cycle, so no ready signal exists and the source never waits. The register port is a plain read/write port with no handshake. Reads are combinational from `reg_addr`, and writes take effect at the clock edge while `reg_wen` is high.

Top module: `ecc_err_log`

## Requirements
- R1: After reset, every register reads zero and `serr` is low.
- R2: A cycle with `ev_ce` high sets the correctable flag, status bit 0 (offset 0x00). A cycle with `ev_ue` high sets the uncorrectable flag, status bit 7. Status bits 15:8 and 6:1 read zero.
- R3: A write to offset 0x00 clears each flag whose bit (0 or 7) is 1 in the write data. A 0 in that bit leaves the flag as it was, so writing 0x0081 clears both flags.
- R4: The address register (offset 0x04) returns the logged block address in bits 31:12, and bits 11:0 read zero.
- R5: The syndrome register (offset 0x08) returns the logged 8-bit syndrome in bits 7:0. The channel register (offset 0x0C) returns the logged channel in bit 0. All their other bits read zero.
- R6: An event that arrives while no flag is set loads the address, syndrome and channel fields from the event inputs.
- R7: An uncorrectable event that arrives while only the correctable flag is set overwrites the address, syndrome and channel fields with its own values.
- R8: A correctable event that arrives while any flag is set does not change the logged fields. No event changes the logged fields while the uncorrectable flag is set.
- R9: When both strobes are high in the same cycle and no uncorrectable error is logged, the fields take the event inputs and both flags are set.
- R10: The command register (offset 0x10) holds the 16 bits last written to it. Bit 8 is the uncorrectable-error enable and bit 7 is the correctable-error enable.
- R11: `serr` equals (uncorrectable flag AND command bit 8) OR (correctable flag AND command bit 7), with no added cycle of delay.
- R12: If a clear write and a new event of the same kind fall in the same cycle, the flag stays set.
- R13: Writes to offsets 0x04, 0x08 and 0x0C and to unmapped offsets have no effect. Reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_ce | input | 1 | Correctable-error event strobe |
| ev_ue | input | 1 | Uncorrectable-error event strobe |
| ev_blk | input | 20 | Failing physical address bits 31:12 |
| ev_syn | input | 8 | ECC syndrome of the event |
| ev_chan | input | 1 | Channel of the event |
| reg_addr | input | 5 | Register byte offset |
| reg_wen | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| serr | output | 1 | System-error level output |

## Verification
The bench uses the default parameters: a 32-bit address with 4 KiB logging granularity (a 20-bit block field), an 8-bit syndrome and one channel bit. With these settings random stimulus can reach every syndrome value, both channels and both ends of the block-address range. Directed sequences drive the severity orderings: correctable then uncorrectable, uncorrectable then correctable, both strobes together, and an event that lands in the same cycle as a clear.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  localparam int OFF_STS  = 'h00;
  localparam int OFF_ADDR = 'h04;
  localparam int OFF_SYN  = 'h08;
  localparam int OFF_CHAN = 'h0C;
  localparam int OFF_CMD  = 'h10;

  localparam int STS_CE_BIT = 0;
  localparam int STS_UE_BIT = 7;
  localparam int CMD_CE_EN  = 7;
  localparam int CMD_UE_EN  = 8;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STS,
    SEL_ADDR,
    SEL_SYN,
    SEL_CHAN,
    SEL_CMD
  } reg_sel_e;
endpackage

// File: rtl/ecc_log_decode.sv
module ecc_log_decode
  import ecc_log_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] addr,
  output reg_sel_e      sel
);
  always_comb begin
    sel = SEL_NONE;
    if (addr == AW'(OFF_STS))  sel = SEL_STS;
    if (addr == AW'(OFF_ADDR)) sel = SEL_ADDR;
    if (addr == AW'(OFF_SYN))  sel = SEL_SYN;
    if (addr == AW'(OFF_CHAN)) sel = SEL_CHAN;
    if (addr == AW'(OFF_CMD))  sel = SEL_CMD;
  end
endmodule

// File: rtl/ecc_log_capture.sv
module ecc_log_capture #(
  parameter int BLK_W = 20,
  parameter int SYN_W = 8,
  parameter int CH_W  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_ce,
  input  logic             ev_ue,
  input  logic [BLK_W-1:0] ev_blk,
  input  logic [SYN_W-1:0] ev_syn,
  input  logic [CH_W-1:0]  ev_chan,
  input  logic             clr_ce,
  input  logic             clr_ue,
  output logic             ce_flag,
  output logic             ue_flag,
  output logic [BLK_W-1:0] log_blk,
  output logic [SYN_W-1:0] log_syn,
  output logic [CH_W-1:0]  log_chan
);
  logic logged;
  logic load;

  // Severity rule: a UE may replace a CE record; nothing replaces a UE record.
  assign logged = ce_flag | ue_flag;
  assign load   = (ev_ue & ~ue_flag) | (ev_ce & ~logged);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_flag  <= 1'b0;
      ue_flag  <= 1'b0;
      log_blk  <= '0;
      log_syn  <= '0;
      log_chan <= '0;
    end else begin
      // A new event wins over a clear in the same cycle.
      ce_flag <= ev_ce | (ce_flag & ~clr_ce);
      ue_flag <= ev_ue | (ue_flag & ~clr_ue);
      if (load) begin
        log_blk  <= ev_blk;
        log_syn  <= ev_syn;
        log_chan <= ev_chan;
      end
    end
  end
endmodule

// File: rtl/ecc_log_cmd.sv
module ecc_log_cmd
  import ecc_log_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [CW-1:0] wdata,
  input  logic          ce_flag,
  input  logic          ue_flag,
  output logic [CW-1:0] cmd_q,
  output logic          serr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cmd_q <= '0;
    else if (wr) cmd_q <= wdata;
  end

  assign serr = (ue_flag & cmd_q[CMD_UE_EN]) | (ce_flag & cmd_q[CMD_CE_EN]);
endmodule

// File: rtl/ecc_log_rdmux.sv
module ecc_log_rdmux
  import ecc_log_pkg::*;
#(
  parameter int RD_W    = 32,
  parameter int BLK_LSB = 12,
  parameter int SYN_W   = 8,
  parameter int CH_W    = 1,
  parameter int CW      = 16
) (
  input  reg_sel_e                  sel,
  input  logic                      ce_flag,
  input  logic                      ue_flag,
  input  logic [RD_W-BLK_LSB-1:0]   log_blk,
  input  logic [SYN_W-1:0]          log_syn,
  input  logic [CH_W-1:0]           log_chan,
  input  logic [CW-1:0]             cmd_q,
  output logic [RD_W-1:0]           rdata
);
  logic [RD_W-1:0] sts_word;

  always_comb begin
    sts_word = '0;
    sts_word[STS_CE_BIT] = ce_flag;
    sts_word[STS_UE_BIT] = ue_flag;
  end

  always_comb begin
    unique case (sel)
      SEL_STS:  rdata = sts_word;
      SEL_ADDR: rdata = {log_blk, {BLK_LSB{1'b0}}};
      SEL_SYN:  rdata = {{(RD_W-SYN_W){1'b0}}, log_syn};
      SEL_CHAN: rdata = {{(RD_W-CH_W){1'b0}}, log_chan};
      SEL_CMD:  rdata = {{(RD_W-CW){1'b0}}, cmd_q};
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
  import ecc_log_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int BLK_LSB = 12,
  parameter int SYN_W   = 8,
  parameter int CH_W    = 1,
  parameter int AW      = 5,
  parameter int CW      = 16,
  localparam int BLK_W  = ADDR_W - BLK_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_ce,
  input  logic              ev_ue,
  input  logic [BLK_W-1:0]  ev_blk,
  input  logic [SYN_W-1:0]  ev_syn,
  input  logic [CH_W-1:0]   ev_chan,
  input  logic [AW-1:0]     reg_addr,
  input  logic              reg_wen,
  input  logic [CW-1:0]     reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  output logic              serr
);
  reg_sel_e         sel;
  logic             ce_flag, ue_flag;
  logic [BLK_W-1:0] log_blk;
  logic [SYN_W-1:0] log_syn;
  logic [CH_W-1:0]  log_chan;
  logic [CW-1:0]    cmd_q;
  logic             sts_wr, clr_ce, clr_ue, cmd_wr;

  ecc_log_decode #(.AW(AW)) u_dec (.addr(reg_addr), .sel(sel));

  assign sts_wr = reg_wen && (sel == SEL_STS);
  assign clr_ce = sts_wr & reg_wdata[STS_CE_BIT];
  assign clr_ue = sts_wr & reg_wdata[STS_UE_BIT];
  assign cmd_wr = reg_wen && (sel == SEL_CMD);

  ecc_log_capture #(.BLK_W(BLK_W), .SYN_W(SYN_W), .CH_W(CH_W)) u_cap (
    .clk(clk), .rst_n(rst_n),
    .ev_ce(ev_ce), .ev_ue(ev_ue), .ev_blk(ev_blk), .ev_syn(ev_syn), .ev_chan(ev_chan),
    .clr_ce(clr_ce), .clr_ue(clr_ue),
    .ce_flag(ce_flag), .ue_flag(ue_flag),
    .log_blk(log_blk), .log_syn(log_syn), .log_chan(log_chan)
  );

  ecc_log_cmd #(.CW(CW)) u_cmd (
    .clk(clk), .rst_n(rst_n), .wr(cmd_wr), .wdata(reg_wdata),
    .ce_flag(ce_flag), .ue_flag(ue_flag), .cmd_q(cmd_q), .serr(serr)
  );

  ecc_log_rdmux #(.RD_W(ADDR_W), .BLK_LSB(BLK_LSB), .SYN_W(SYN_W), .CH_W(CH_W), .CW(CW)) u_rd (
    .sel(sel), .ce_flag(ce_flag), .ue_flag(ue_flag),
    .log_blk(log_blk), .log_syn(log_syn), .log_chan(log_chan),
    .cmd_q(cmd_q), .rdata(reg_rdata)
  );
endmodule

// File: rtl/ecc_err_log_chk.sv
module ecc_err_log_chk
  import ecc_log_pkg::*;
#(
  parameter int BLK_LSB = 12,
  parameter int BLK_W   = 20,
  parameter int SYN_W   = 8,
  parameter int CH_W    = 1,
  parameter int AW      = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ev_ce,
  input logic               ev_ue,
  input logic [SYN_W-1:0]   ev_syn,
  input logic [CH_W-1:0]    ev_chan,
  input logic [AW-1:0]      reg_addr,
  input logic               reg_wen,
  input logic               wd_ce,
  input logic [BLK_LSB-1:0] rd_low,
  input logic               serr,
  input logic               ce_flag,
  input logic               ue_flag,
  input logic [BLK_W-1:0]   log_blk,
  input logic [SYN_W-1:0]   log_syn,
  input logic [CH_W-1:0]    log_chan,
  input logic               en_ue,
  input logic               en_ce
);
  logic clr_ce_wr;
  assign clr_ce_wr = reg_wen && (reg_addr == AW'(OFF_STS)) && wd_ce;

  p_ce_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ce |=> ce_flag);
  p_ue_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ue |=> ue_flag);
  p_ce_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ce_wr && !ev_ce) |=> !ce_flag);
  p_ce_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_flag && !clr_ce_wr) |=> ce_flag);
  p_ue_over_ce_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ue && !ue_flag) |=> (log_syn == $past(ev_syn)) && (log_chan == $past(ev_chan)));
  p_ue_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ue_flag |=> $stable(log_blk) && $stable(log_syn) && $stable(log_chan));
  p_ce_no_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_flag && !ev_ue) |=> $stable(log_blk) && $stable(log_syn) && $stable(log_chan));
  p_serr_level_r11: assert property (@(posedge clk) disable iff (!rst_n)
    serr == ((ue_flag && en_ue) || (ce_flag && en_ce)));

  // R4: low address bits never carry data
  always_comb begin
    if (rst_n && reg_addr == AW'(OFF_ADDR))
      p_addr_low_zero_r4: assert (rd_low == '0);
  end
endmodule

bind ecc_err_log ecc_err_log_chk #(
  .BLK_LSB(BLK_LSB), .BLK_W(BLK_W), .SYN_W(SYN_W), .CH_W(CH_W), .AW(AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_ce(ev_ce), .ev_ue(ev_ue),
  .ev_syn(ev_syn), .ev_chan(ev_chan),
  .reg_addr(reg_addr), .reg_wen(reg_wen), .wd_ce(reg_wdata[0]),
  .rd_low(reg_rdata[BLK_LSB-1:0]), .serr(serr),
  .ce_flag(ce_flag), .ue_flag(ue_flag),
  .log_blk(log_blk), .log_syn(log_syn), .log_chan(log_chan),
  .en_ue(cmd_q[8]), .en_ce(cmd_q[7])
);

// File: tb/tb_ecc_err_log.sv
module tb_ecc_err_log;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_ce = 1'b0, ev_ue = 1'b0;
  logic [19:0] ev_blk = '0;
  logic [7:0]  ev_syn = '0;
  logic        ev_chan = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic        reg_wen = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        serr;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference state
  logic        m_ce = 0, m_ue = 0, m_chan = 0;
  logic [19:0] m_blk = '0;
  logic [7:0]  m_syn = '0;
  logic [15:0] m_cmd = '0;

  always #5 clk = ~clk;

  ecc_err_log dut (
    .clk(clk), .rst_n(rst_n), .ev_ce(ev_ce), .ev_ue(ev_ue), .ev_blk(ev_blk),
    .ev_syn(ev_syn), .ev_chan(ev_chan), .reg_addr(reg_addr), .reg_wen(reg_wen),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .serr(serr)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_sts();
    return {24'h0, m_ue, 6'h0, m_ce};
  endfunction

  function automatic logic exp_serr();
    return (m_ue & m_cmd[8]) | (m_ce & m_cmd[7]);
  endfunction

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic check_all(string ctx);
    logic [31:0] d;
    rd(5'h00, d); chk({"R2 status ", ctx}, d, exp_sts());
    rd(5'h04, d); chk({"R4 addr ", ctx}, d, {m_blk, 12'h0});
    rd(5'h08, d); chk({"R5 syndrome ", ctx}, d, {24'h0, m_syn});
    rd(5'h0C, d); chk({"R5 channel ", ctx}, d, {31'h0, m_chan});
    rd(5'h10, d); chk({"R10 command ", ctx}, d, {16'h0, m_cmd});
    rd(5'h14, d); chk({"R13 unmapped ", ctx}, d, 32'h0);
    chk({"R11 serr ", ctx}, {31'h0, serr}, {31'h0, exp_serr()});
  endtask

  // model update, from the requirements
  task automatic model(logic ce, logic ue, logic [19:0] b, logic [7:0] s, logic ch,
                       logic w, logic [4:0] a, logic [15:0] wd);
    logic ld;
    ld = (ue && !m_ue) || (ce && !m_ce && !m_ue);
    if (ld) begin m_blk = b; m_syn = s; m_chan = ch; end
    m_ce = ce | (m_ce & ~(w && a == 5'h00 && wd[0]));
    m_ue = ue | (m_ue & ~(w && a == 5'h00 && wd[7]));
    if (w && a == 5'h10) m_cmd = wd;
  endtask

  task automatic cyc(logic ce, logic ue, logic [19:0] b, logic [7:0] s, logic ch,
                     logic w, logic [4:0] a, logic [15:0] wd);
    @(negedge clk);
    ev_ce = ce; ev_ue = ue; ev_blk = b; ev_syn = s; ev_chan = ch;
    reg_wen = w; reg_addr = a; reg_wdata = wd;
    @(posedge clk);
    model(ce, ue, b, s, ch, w, a, wd);
    #1;
    ev_ce = 0; ev_ue = 0; reg_wen = 0;
  endtask

  task automatic ev(logic ce, logic ue, logic [19:0] b, logic [7:0] s, logic ch);
    cyc(ce, ue, b, s, ch, 1'b0, 5'h00, 16'h0);
  endtask

  task automatic wr(logic [4:0] a, logic [15:0] wd);
    cyc(1'b0, 1'b0, 20'h0, 8'h0, 1'b0, 1'b1, a, wd);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0A17));
    #1; chk("R1 serr in reset", {31'h0, serr}, 32'h0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    check_all("R1 after reset");

    // R6: first CE loads fields
    ev(1, 0, 20'hABCDE, 8'h3C, 1'b1);
    check_all("R6 first ce");
    // R8: second CE keeps fields
    ev(1, 0, 20'h11111, 8'h55, 1'b0);
    check_all("R8 ce while ce");
    // R7: UE overwrites pending CE
    ev(0, 1, 20'hFFFFF, 8'hE7, 1'b0);
    check_all("R7 ue over ce");
    // R8: neither kind overwrites UE
    ev(1, 0, 20'h00001, 8'h01, 1'b1);
    ev(0, 1, 20'h00002, 8'h02, 1'b1);
    check_all("R8 hold under ue");
    // R13: writes to read-only offsets ignored
    wr(5'h04, 16'hFFFF); wr(5'h08, 16'hFFFF); wr(5'h0C, 16'hFFFF); wr(5'h14, 16'hFFFF);
    check_all("R13 ro writes");
    // R10/R11: enables
    wr(5'h10, 16'h0100); check_all("R11 ue enable");
    wr(5'h10, 16'h0080); check_all("R11 ce enable");
    // R3: write zero then single-bit clears
    wr(5'h00, 16'h0000); check_all("R3 write zero");
    wr(5'h00, 16'h0001); check_all("R3 clear ce only");
    wr(5'h10, 16'hA5C3); check_all("R10 full word");
    wr(5'h00, 16'h0080); check_all("R3 clear ue only");
    // R9: both strobes on empty log
    ev(1, 1, 20'h0F0F0, 8'h99, 1'b1);
    check_all("R9 both strobes");
    // R12: clear and event same cycle
    cyc(1, 0, 20'h12345, 8'h77, 1'b0, 1'b1, 5'h00, 16'h0081);
    check_all("R12 ce wins over clear");
    wr(5'h00, 16'h0081); check_all("R3 mask clears both");
    ev(0, 1, 20'h54321, 8'h44, 1'b1);
    cyc(0, 1, 20'h00000, 8'h00, 1'b0, 1'b1, 5'h00, 16'h0081);
    check_all("R12 ue wins over clear");
    wr(5'h00, 16'h0081);

    // random phase
    for (int i = 0; i < 400; i++) begin
      logic ce, ue, w, ch;
      logic [4:0] a;
      logic [15:0] wd;
      ce = ($urandom % 4) == 0;
      ue = ($urandom % 8) == 0;
      w  = ($urandom % 3) == 0;
      ch = $urandom % 2;
      a  = 5'(($urandom % 6) * 4);
      case ($urandom % 4)
        0: wd = 16'h0081;
        1: wd = 16'h0001;
        2: wd = 16'h0080;
        default: wd = 16'($urandom);
      endcase
      cyc(ce, ue, 20'($urandom), 8'($urandom), ch, w, a, wd);
      check_all("R2 random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule